// File: doc/BRIEF.md
# Render-Engine Interrupt Controller

This block collects the interrupt sources of a tile-based graphics engine and presents them to the host as one interrupt line behind a small register bus. There are three sources. Two are events: a pulse when the binner finishes flushing a frame and a pulse when a frame render completes. The third is a condition: the binner is out of memory. A pending bit for each source sits in a status register, and writing a one to a bit of that register acknowledges it. Software changes the single enable mask through two write-only-effect ports: one register sets mask bits and the other clears them. Either register reads back the mask.

The out-of-memory source is a level. It is asserted from reset, because no spare memory has been handed over yet, and it is asserted again whenever the binner reports that it has used up the pool it was given. Software removes the condition by writing a pool base address and then a pool size. Until that pair of writes has happened in that order, acknowledging the out-of-memory bit does not keep it clear: the bit comes back on the next cycle. Several sources can be enabled, disabled or acknowledged in a single write.

Top module: `rfx_irq_ctrl`

## Requirements
- R1: After reset the status bits, the enable mask, the pool address and the pool size are all zero, and `irq_o` is low. The out-of-memory condition is pending from reset, so status bit 2 reads 1 from the second cycle after reset is released.
- R2: Status, enable-set and enable-clear use this layout: bit 0 is render done, bit 1 is flush done and bit 2 is out of memory. Bits 31..3 read as zero, and writes to them have no effect.
- R3: A write to the status register (offset 0x00) clears each status bit that is written as 1 and leaves each bit written as 0 unchanged. One write can clear several bits.
- R4: A write to enable-set (offset 0x04) sets the mask bits that are written as 1. A write to enable-clear (offset 0x08) clears the mask bits that are written as 1. Zero bits have no effect in either register.
- R5: A read of offset 0x04 returns the current enable mask, and so does a read of offset 0x08.
- R6: A one-cycle pulse on `render_done_i` or on `flush_done_i` sets its status bit. After the bit is acknowledged it stays clear until another pulse arrives.
- R7: While the out-of-memory condition holds, status bit 2 is set again on the cycle after any acknowledge.
- R8: A write to pool size (offset 0x10) removes the out-of-memory condition only when a write to pool address (offset 0x0C) has come before it and no exhaust pulse has arrived in between. A pulse on `bin_exhaust_i` asserts the condition again. The pool registers drive `pool_addr_o` and `pool_size_o`.
- R9: `irq_o` is the registered OR of (status AND enable), so it follows a change in status or enable one cycle later.
- R10: A status bit latches its source even while that source is disabled. A later enable then raises `irq_o`.
- R11: When a source sets a status bit in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R12: `bus_rdata_o` holds, in the cycle after a read strobe, the value the addressed register had at the strobe edge. Unmapped offsets read as zero, and the output is zero after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the register |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| render_done_i | input | 1 | Pulse: a frame render completed |
| flush_done_i | input | 1 | Pulse: the binner finished flushing a frame |
| bin_exhaust_i | input | 1 | Pulse: the binner used up its overflow pool |
| irq_o | output | 1 | Interrupt request to the host |
| pool_addr_o | output | DATA_W (32) | Overflow pool base address |
| pool_size_o | output | DATA_W (32) | Overflow pool size |

## Verification
The bench checks three cases for the out-of-memory bit: an acknowledge while memory is still short, a size write with no address write before it, and a properly ordered pool hand-over. A design that treated the bit as an event would let it stay clear too early. A design that ignored the ordering would clear the condition on a bare size write. The bench also sends an event in the same cycle as its acknowledge, where a design that gave the clear priority would lose an interrupt. It lets a disabled source latch its bit and then enables it, where a design that gated latching by the enable would never raise the line. The bench also checks the one-cycle lag of `irq_o` after an enable change, which catches a design that drives the line combinationally. It checks that a zero bit in any write leaves the state untouched.

// File: rtl/rfx_irq_pkg.sv
package rfx_irq_pkg;
    localparam int unsigned NUM_SRC    = 3;
    localparam int unsigned BIT_RENDER = 0;
    localparam int unsigned BIT_FLUSH  = 1;
    localparam int unsigned BIT_OOM    = 2;

    localparam int unsigned OFS_STATUS    = 'h00;
    localparam int unsigned OFS_EN_SET    = 'h04;
    localparam int unsigned OFS_EN_CLR    = 'h08;
    localparam int unsigned OFS_POOL_ADDR = 'h0C;
    localparam int unsigned OFS_POOL_SIZE = 'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_POOL_ADDR,
        SEL_POOL_SIZE
    } reg_sel_e;
endpackage

// File: rtl/rfx_irq_status.sv
module rfx_irq_status #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            // a source that fires wins against an acknowledge in the same cycle
            if (set_i[i]) begin
                state_d.pend[i] = 1'b1;
            end else if (clr_i[i]) begin
                state_d.pend[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.pend;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[k] |=> status_o[k]);
        p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[k] && !set_i[k]) |=> !status_o[k]);
        p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_i[k] && !set_i[k]) |=> $stable(status_o[k]));
    end
endmodule

// File: rtl/rfx_irq_enable.sv
module rfx_irq_enable #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] mask_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.mask = (state_q.mask | set_i) & ~clr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.mask;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_i[k] && !clr_i[k]) |=> mask_o[k]);
        p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i[k] |=> !mask_o[k]);
        p_zero_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!set_i[k] && !clr_i[k]) |=> $stable(mask_o[k]));
    end
endmodule

// File: rtl/rfx_ovf_pool.sv
module rfx_ovf_pool #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              addr_wr_i,
    input  logic              size_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              exhaust_i,
    output logic [DATA_W-1:0] pool_addr_o,
    output logic [DATA_W-1:0] pool_size_o,
    output logic              need_mem_o
);
    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] size;
        logic              armed;
        logic              need;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (addr_wr_i) begin
            state_d.base = wdata_i;
        end
        if (size_wr_i) begin
            state_d.size = wdata_i;
        end
        if (exhaust_i) begin
            state_d.need  = 1'b1;
            state_d.armed = 1'b0;
        end else if (size_wr_i && state_q.armed) begin
            state_d.need  = 1'b0;
            state_d.armed = 1'b0;
        end else if (addr_wr_i) begin
            state_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q       <= '0;
            state_q.need  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign pool_addr_o = state_q.base;
    assign pool_size_o = state_q.size;
    assign need_mem_o  = state_q.need;

    p_exhaust_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exhaust_i |=> need_mem_o);
    p_bare_size_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (need_mem_o && !addr_wr_i && !$past(addr_wr_i) && !state_q.armed) |=> need_mem_o);
    p_pool_given_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (size_wr_i && state_q.armed && !exhaust_i) |=> !need_mem_o);
endmodule

// File: rtl/rfx_irq_ctrl.sv
module rfx_irq_ctrl
    import rfx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              render_done_i,
    input  logic              flush_done_i,
    input  logic              bin_exhaust_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] pool_addr_o,
    output logic [DATA_W-1:0] pool_size_o
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    typedef struct packed {
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] wr_bits;
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] ack_mask;
    logic [NUM_SRC-1:0] en_set_mask;
    logic [NUM_SRC-1:0] en_clr_mask;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic               need_mem;
    logic               pool_addr_wr;
    logic               pool_size_wr;

    always_comb begin
        if (bus_addr_i == ADDR_W'(OFS_STATUS)) begin
            sel = SEL_STATUS;
        end else if (bus_addr_i == ADDR_W'(OFS_EN_SET)) begin
            sel = SEL_EN_SET;
        end else if (bus_addr_i == ADDR_W'(OFS_EN_CLR)) begin
            sel = SEL_EN_CLR;
        end else if (bus_addr_i == ADDR_W'(OFS_POOL_ADDR)) begin
            sel = SEL_POOL_ADDR;
        end else if (bus_addr_i == ADDR_W'(OFS_POOL_SIZE)) begin
            sel = SEL_POOL_SIZE;
        end else begin
            sel = SEL_NONE;
        end
    end

    assign wr_bits      = bus_wdata_i[NUM_SRC-1:0];
    assign ack_mask     = (bus_wr_i && sel == SEL_STATUS) ? wr_bits : '0;
    assign en_set_mask  = (bus_wr_i && sel == SEL_EN_SET) ? wr_bits : '0;
    assign en_clr_mask  = (bus_wr_i && sel == SEL_EN_CLR) ? wr_bits : '0;
    assign pool_addr_wr = bus_wr_i && (sel == SEL_POOL_ADDR);
    assign pool_size_wr = bus_wr_i && (sel == SEL_POOL_SIZE);

    always_comb begin
        src_set             = '0;
        src_set[BIT_RENDER] = render_done_i;
        src_set[BIT_FLUSH]  = flush_done_i;
        src_set[BIT_OOM]    = need_mem;
    end

    rfx_irq_status #(.NUM_SRC(NUM_SRC)) i_status (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (src_set),
        .clr_i    (ack_mask),
        .status_o (status)
    );

    rfx_irq_enable #(.NUM_SRC(NUM_SRC)) i_enable (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (en_set_mask),
        .clr_i  (en_clr_mask),
        .mask_o (enable)
    );

    rfx_ovf_pool #(.DATA_W(DATA_W)) i_pool (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .addr_wr_i   (pool_addr_wr),
        .size_wr_i   (pool_size_wr),
        .wdata_i     (bus_wdata_i),
        .exhaust_i   (bin_exhaust_i),
        .pool_addr_o (pool_addr_o),
        .pool_size_o (pool_size_o),
        .need_mem_o  (need_mem)
    );

    always_comb begin
        state_d       = state_q;
        state_d.irq   = |(status & enable);
        state_d.rdata = '0;
        if (bus_rd_i) begin
            unique case (sel)
                SEL_STATUS:    state_d.rdata = {{PAD_W{1'b0}}, status};
                SEL_EN_SET,
                SEL_EN_CLR:    state_d.rdata = {{PAD_W{1'b0}}, enable};
                SEL_POOL_ADDR: state_d.rdata = pool_addr_o;
                SEL_POOL_SIZE: state_d.rdata = pool_size_o;
                default:       state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o       = state_q.irq;
    assign bus_rdata_o = state_q.rdata;

    p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(status & enable)) |=> irq_o);
    p_irq_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(status & enable)) |=> !irq_o);
    p_oom_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        need_mem |=> status[BIT_OOM]);
    p_idle_read_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_rd_i |=> (bus_rdata_o == '0));
    p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[DATA_W-1:NUM_SRC] == '0 || $past(sel == SEL_POOL_ADDR || sel == SEL_POOL_SIZE));
endmodule

// File: tb/test_rfx_irq_ctrl.sv
module test_rfx_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  baddr = '0;
    logic        bwr = 1'b0;
    logic        brd = 1'b0;
    logic [31:0] bwdata = '0;
    logic [31:0] brdata;
    logic        ev_render = 1'b0;
    logic        ev_flush = 1'b0;
    logic        ev_exhaust = 1'b0;
    logic        irq;
    logic [31:0] paddr_o;
    logic [31:0] psize_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rfx_irq_ctrl i_rfx_irq_ctrl (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .bus_addr_i    (baddr),
        .bus_wr_i      (bwr),
        .bus_rd_i      (brd),
        .bus_wdata_i   (bwdata),
        .bus_rdata_o   (brdata),
        .render_done_i (ev_render),
        .flush_done_i  (ev_flush),
        .bin_exhaust_i (ev_exhaust),
        .irq_o         (irq),
        .pool_addr_o   (paddr_o),
        .pool_size_o   (psize_o)
    );

    // behavioural reference model
    logic [2:0]  m_st, m_en;
    logic        m_need, m_armed, m_irq;
    logic [31:0] m_pa, m_ps, m_rd;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:        return {29'd0, m_st};
            8'h04, 8'h08: return {29'd0, m_en};
            8'h0C:        return m_pa;
            8'h10:        return m_ps;
            default:      return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_en <= 0; m_need <= 1; m_armed <= 0;
            m_irq <= 0; m_pa <= 0; m_ps <= 0; m_rd <= 0;
        end else begin
            logic [2:0] ack;
            logic [2:0] src;
            ack = (bwr && baddr == 8'h00) ? bwdata[2:0] : 3'b000;
            src = {m_need, ev_flush, ev_render};
            m_st  <= src | (m_st & ~ack);
            m_irq <= |(m_st & m_en);
            m_rd  <= brd ? m_read(baddr) : 32'd0;
            if (bwr && baddr == 8'h04) m_en <= m_en | bwdata[2:0];
            if (bwr && baddr == 8'h08) m_en <= m_en & ~bwdata[2:0];
            if (bwr && baddr == 8'h0C) m_pa <= bwdata;
            if (bwr && baddr == 8'h10) m_ps <= bwdata;
            if (ev_exhaust) begin
                m_need <= 1; m_armed <= 0;
            end else if (bwr && baddr == 8'h10 && m_armed) begin
                m_need <= 0; m_armed <= 0;
            end else if (bwr && baddr == 8'h0C) begin
                m_armed <= 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            chk("R12 rdata vs model", brdata, m_rd);
            chk("R8 pool_addr vs model", paddr_o, m_pa);
            chk("R8 pool_size vs model", psize_o, m_ps);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        baddr = a; bwdata = d; bwr = 1'b1;
        @(negedge clk);
        bwr = 1'b0; bwdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        baddr = a; brd = 1'b1;
        @(negedge clk);
        brd = 1'b0;
        chk(tag, brdata, exp);
    endtask

    task automatic pulse(input logic r, input logic f, input logic x);
        ev_render = r; ev_flush = f; ev_exhaust = x;
        @(negedge clk);
        ev_render = 1'b0; ev_flush = 1'b0; ev_exhaust = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq low in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        // R1 reset values, R7 condition pending from reset
        rd(8'h00, 32'h4, "R1 status after reset");
        rd(8'h04, 32'h0, "R1 enable after reset");
        rd(8'h0C, 32'h0, "R1 pool addr after reset");
        rd(8'h10, 32'h0, "R1 pool size after reset");
        rd(8'h14, 32'h0, "R12 unmapped offset");
        // R4 / R5 enable pair
        wr(8'h04, 32'h5);
        rd(8'h08, 32'h5, "R5 enable read via clear register");
        wr(8'h04, 32'h2);
        rd(8'h04, 32'h7, "R4 set adds bit");
        wr(8'h08, 32'h2);
        rd(8'h04, 32'h5, "R4 clear removes only written bit");
        wr(8'h04, 32'h0);
        rd(8'h08, 32'h5, "R4 zero write ignored");
        // R7 level source re-asserts
        wr(8'h00, 32'h4);
        idle(1);
        rd(8'h00, 32'h4, "R7 oom sets again after ack");
        // R8 bare size write does not remove the condition
        wr(8'h10, 32'h100);
        wr(8'h00, 32'h4);
        idle(1);
        rd(8'h00, 32'h4, "R8 size without address");
        rd(8'h10, 32'h100, "R12 pool size readback");
        // R8 ordered hand-over
        wr(8'h0C, 32'h8000);
        wr(8'h10, 32'h200);
        wr(8'h00, 32'h4);
        idle(1);
        rd(8'h00, 32'h0, "R8 ack holds after pool given");
        rd(8'h0C, 32'h8000, "R12 pool addr readback");
        // R6 event latch, R3 zero bits
        pulse(1, 0, 0);
        rd(8'h00, 32'h1, "R2 render done is bit 0");
        wr(8'h00, 32'h6);
        rd(8'h00, 32'h1, "R3 zero bit leaves status");
        wr(8'h00, 32'h1);
        idle(3);
        rd(8'h00, 32'h0, "R6 stays clear after ack");
        // R10 latch while disabled (mask = 5, flush disabled)
        pulse(0, 1, 0);
        idle(1);
        chk("R10 disabled source keeps irq low", {31'd0, irq}, 32'd0);
        rd(8'h00, 32'h2, "R10 flush latched while disabled");
        wr(8'h04, 32'h2);
        idle(1);
        chk("R10 enable raises irq", {31'd0, irq}, 32'd1);
        wr(8'h08, 32'h7);
        chk("R9 irq one cycle behind enable", {31'd0, irq}, 32'd1);
        idle(1);
        chk("R9 irq low after disable", {31'd0, irq}, 32'd0);
        // R11 event against ack in same cycle
        ev_flush = 1'b1;
        wr(8'h00, 32'h2);
        ev_flush = 1'b0;
        rd(8'h00, 32'h2, "R11 event wins over ack");
        // R3 multi ack
        pulse(1, 1, 0);
        rd(8'h00, 32'h3, "R6 both events latched");
        wr(8'h00, 32'h7);
        rd(8'h00, 32'h0, "R3 one write clears several");
        // R2 upper bits
        wr(8'h04, 32'hFFFF_FFF8);
        rd(8'h04, 32'h0, "R2 upper enable bits ignored");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R2 upper status bits read zero");
        // R8 exhaust re-asserts, R9 irq
        pulse(0, 0, 1);
        idle(1);
        rd(8'h00, 32'h4, "R8 exhaust pulse re-asserts oom");
        wr(8'h04, 32'h4);
        idle(1);
        chk("R9 irq from oom", {31'd0, irq}, 32'd1);
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule